// File: doc/BRIEF.md
# Paced ADC Sequencer with Overrun Lockout

This block sequences an external analog-to-digital converter. Conversions are launched either by a host command or by a programmable pacer timer. Each launch is a one-cycle start pulse. Results come back through a done strobe with the sample value. They land in a sample store: a single holding slot, or a FIFO of `DEPTH` entries when buffering is switched on.

The host reads a sample in two byte reads, low byte first. Reading the high byte retires the sample. While the pacer runs, the next conversion may already be in flight before the last result has been read. If a result arrives and finds no free space, the block latches a sticky error, discards the new result and freezes the pacer until software clears the error. The block also drives the channel and gain selection lines and an interrupt request.

Top module: `adc_pace_seq`

## Requirements
- R1: After reset, `adc_start`, `irq`, `chan_sel` and `gain_sel` are 0, and the status register (address 3) reads 0.
- R2: In mode 0 (control bits 1:0 = 0), a write to address 7 drives `adc_start` high for exactly one cycle, in the cycle after the write. In modes 1 to 3 that write launches nothing.
- R3: In modes 1 to 3, with no error latched, `adc_start` pulses for one cycle every N+1 cycles. N is the 16-bit reload value written at address 4 (low byte) and address 5 (high byte).
- R4: Address 0 reads sample bits 7:0 of the oldest unread sample. Address 1 reads bits 11:8, zero-extended. A read of address 1 retires that sample. Status bit 0 is 1 while any sample is unread.
- R5: When buffering is off (control bit 2 = 0), a result that arrives while a sample is unread sets status bit 1 (error). The new result is dropped and the older sample stays readable.
- R6: While the error bit is set, the pacer issues no start pulse. Writing 1 to status bit 1 clears the error, and pacing resumes.
- R7: If an overrun and a clear of the error bit fall in the same cycle, the error bit stays set.
- R8: In holding mode, a result that arrives in the same cycle as the high-byte read of the unread sample is not an overrun. It becomes the new unread sample.
- R9: With buffering on, up to DEPTH results are returned in arrival order. A result that arrives while DEPTH samples are unread sets the error bit and is dropped.
- R10: Status bit 2 is 1 when at least DEPTH/2 samples are unread. With control bit 3 set, `irq` is high when a sample is unread (holding mode) or when status bit 2 is set (buffered mode). With control bit 3 clear, `irq` is low.
- R11: A write to address 6 sets `chan_sel` from bits 3:0 and `gain_sel` from bits 5:4, effective in the next cycle. Address 6 reads the value back.
- R12: A read of address 1 with no unread sample changes nothing. The next result is still stored and returned normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (side effects at address 1) |
| addr | input | 3 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from `addr` |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_done | input | 1 | Conversion result valid strobe |
| adc_data | input | SAMPLE_W | Conversion result |
| chan_sel | output | 4 | Input channel select |
| gain_sel | output | 2 | Gain select |
| irq | output | 1 | Interrupt request, level |

## Verification
Two pairs of functions can land in the same clock. The first pair is an overrun and the host's write that clears the error bit. The second is a result arriving and the high-byte read that retires the only unread sample.

The bench provokes each pair by driving the done strobe and the register access on the same clock edge. For the first pair it then expects the error bit to remain set. For the second it expects no error and the new sample at the data registers. Before each step, a known unread sample and a known error state are set up.

// File: rtl/adc_pace_seq_pkg.sv
package adc_pace_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SOFT   = 2'd0,
        MODE_PACE_A = 2'd1,
        MODE_PACE_B = 2'd2,
        MODE_PACE_C = 2'd3
    } acq_mode_e;

    typedef struct packed {
        logic      irq_en;
        logic      fifo_en;
        acq_mode_e mode;
    } ctrl_t;

    localparam logic [2:0] A_DLO  = 3'd0;
    localparam logic [2:0] A_DHI  = 3'd1;
    localparam logic [2:0] A_CTRL = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_DIVL = 3'd4;
    localparam logic [2:0] A_DIVH = 3'd5;
    localparam logic [2:0] A_MUX  = 3'd6;
    localparam logic [2:0] A_TRIG = 3'd7;

    localparam int ST_AVAIL = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_HALF  = 2;

    localparam int DIV_W = 16;

    function automatic logic is_paced(acq_mode_e m);
        return m != MODE_SOFT;
    endfunction

endpackage

// File: rtl/adc_pacer.sv
module adc_pacer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (!run) begin
                cnt <= reload;
            end else if (cnt == '0) begin
                cnt  <= reload;
                tick <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 2048
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fifo_en,
    input  logic                        push,
    input  logic                        pop,
    input  logic [W-1:0]                din,
    output logic [W-1:0]                head,
    output logic [$clog2(DEPTH):0]      count,
    output logic                        full,
    output logic                        empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    // Holding mode exposes a capacity of one entry.
    assign full  = fifo_en ? (count == CW'(DEPTH)) : !empty;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/adc_pace_seq.sv
module adc_pace_seq
    import adc_pace_seq_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 2048
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [2:0]          addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic                adc_start,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic [3:0]          chan_sel,
    output logic [1:0]          gain_sel,
    output logic                irq
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    ctrl_t              ctrl_q;
    logic [DIV_W-1:0]   div_q;
    logic               err_q;
    logic               sw_start_q;
    logic               pace_tick;

    logic [SAMPLE_W-1:0] head;
    logic [CW-1:0]       count;
    logic                full, empty;
    logic                pop, push, overrun, err_clr, half, avail;
    logic [15:0]         head_ext;

    assign pop     = rd_en && (addr == A_DHI) && !empty;
    assign push    = adc_done && (!full || pop);
    assign overrun = adc_done && full && !pop;
    assign err_clr = wr_en && (addr == A_STAT) && wdata[ST_ERR];
    assign avail   = !empty;
    assign half    = (count >= CW'(HALF));
    assign irq     = ctrl_q.irq_en && (ctrl_q.fifo_en ? half : avail);
    assign head_ext = 16'(head);

    adc_pacer #(.W(DIV_W)) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .run    (is_paced(ctrl_q.mode) && !err_q),
        .reload (div_q),
        .tick   (pace_tick)
    );

    adc_sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (ctrl_q.fifo_en),
        .push    (push),
        .pop     (pop),
        .din     (adc_data),
        .head    (head),
        .count   (count),
        .full    (full),
        .empty   (empty)
    );

    assign adc_start = pace_tick || sw_start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            div_q      <= '0;
            err_q      <= 1'b0;
            sw_start_q <= 1'b0;
            chan_sel   <= '0;
            gain_sel   <= '0;
        end else begin
            sw_start_q <= wr_en && (addr == A_TRIG) && !is_paced(ctrl_q.mode);
            // A fresh overrun outranks a clear in the same cycle.
            if (overrun)      err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
            if (wr_en) begin
                case (addr)
                    A_CTRL: ctrl_q      <= ctrl_t'(wdata[3:0]);
                    A_DIVL: div_q[7:0]  <= wdata;
                    A_DIVH: div_q[15:8] <= wdata;
                    A_MUX: begin
                        chan_sel <= wdata[3:0];
                        gain_sel <= wdata[5:4];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            A_DLO:   rdata = head_ext[7:0];
            A_DHI:   rdata = head_ext[15:8];
            A_CTRL:  rdata = {4'b0, ctrl_q};
            A_STAT:  rdata = {5'b0, half, err_q, avail};
            A_DIVL:  rdata = div_q[7:0];
            A_DIVH:  rdata = div_q[15:8];
            A_MUX:   rdata = {2'b0, gain_sel, chan_sel};
            default: rdata = 8'h00;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{wdata[7:6]};
endmodule

// File: rtl/adc_pace_seq_chk.sv
module adc_pace_seq_chk
    import adc_pace_seq_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [2:0]             addr,
    input logic [7:0]             wdata,
    input logic                   adc_done,
    input logic                   adc_start,
    input logic                   err_q,
    input logic                   full,
    input logic [$clog2(DEPTH):0] count,
    input ctrl_t                  ctrl_q
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic clr_w, hi_rd, ovr_w;
    assign clr_w = wr_en && (addr == A_STAT) && wdata[ST_ERR];
    assign hi_rd = rd_en && (addr == A_DHI);
    assign ovr_w = adc_done && full && !(hi_rd && count != '0);

    p_overrun_sets_err_r5: assert property (@(posedge clk) disable iff (rst)
        ovr_w |=> err_q);

    p_clear_loses_r7: assert property (@(posedge clk) disable iff (rst)
        (ovr_w && clr_w) |=> err_q);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_w) |=> err_q);

    p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (err_q && clr_w && !ovr_w) |=> !err_q);

    p_err_stops_pacer_r6: assert property (@(posedge clk) disable iff (rst)
        (err_q && ctrl_q.mode != MODE_SOFT) |=> !adc_start);

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_empty_read_r12: assert property (@(posedge clk) disable iff (rst)
        (hi_rd && count == '0 && !adc_done) |=> count == '0);
endmodule

bind adc_pace_seq adc_pace_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .adc_done  (adc_done),
    .adc_start (adc_start),
    .err_q     (err_q),
    .full      (full),
    .count     (count),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_adc_pace_seq.sv
`timescale 1ns/1ps
module tb_adc_pace_seq;
    localparam int SW = 12;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, adc_done = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [SW-1:0] adc_data = '0;
    logic [7:0] rdata;
    logic adc_start, irq;
    logic [3:0] chan_sel;
    logic [1:0] gain_sel;

    int total = 0, bad = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    adc_pace_seq #(.SAMPLE_W(SW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .adc_start(adc_start), .adc_done(adc_done),
        .adc_data(adc_data), .chan_sel(chan_sel), .gain_sel(gain_sel), .irq(irq)
    );

    // {sample, expected low byte, expected high byte}
    localparam logic [27:0] VEC [0:4] = '{
        {12'h000, 8'h00, 8'h00},
        {12'hFFF, 8'hFF, 8'h0F},
        {12'hA5C, 8'h5C, 8'h0A},
        {12'h3C1, 8'hC1, 8'h03},
        {12'h800, 8'h00, 8'h08}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus/converter cycle, then one idle cycle.
    task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                       input logic [7:0] wd, input logic dn, input logic [SW-1:0] dd,
                       output logic [7:0] q);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = wd; adc_done = dn; adc_data = dd;
        #1 q = rdata;
        @(negedge clk);
        wr_en = 0; rd_en = 0; adc_done = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q;
        cyc(1, 0, a, d, 0, '0, q);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] q);
        cyc(0, 1, a, 8'h00, 0, '0, q);
    endtask

    task automatic done(input logic [SW-1:0] d);
        logic [7:0] q;
        cyc(0, 0, 3'd0, 8'h00, 1, d, q);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 start", {15'd0, adc_start}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 chan/gain", {10'd0, gain_sel, chan_sel}, 16'd0);
        rd(3'd3, rv); chk("R1 status", {8'd0, rv}, 16'd0);

        // R4 vector table in holding mode
        for (int i = 0; i < 5; i++) begin
            done(VEC[i][27:16]);
            rd(3'd3, rv); chk("R4 avail", {8'd0, rv}, 16'h0001);
            rd(3'd0, rv); chk("R4 low", {8'd0, rv}, {8'd0, VEC[i][15:8]});
            rd(3'd1, rv); chk("R4 high", {8'd0, rv}, {8'd0, VEC[i][7:0]});
            rd(3'd3, rv); chk("R4 retired", {8'd0, rv}, 16'h0000);
        end

        // R11 channel and gain
        wr(3'd6, 8'h2B);
        chk("R11 chan", {12'd0, chan_sel}, 16'h000B);
        chk("R11 gain", {14'd0, gain_sel}, 16'h0002);
        rd(3'd6, rv); chk("R11 readback", {8'd0, rv}, 16'h002B);

        // R2 software start in mode 0
        @(negedge clk); wr_en = 1; addr = 3'd7;
        @(negedge clk); wr_en = 0;
        chk("R2 pulse", {15'd0, adc_start}, 16'd1);
        @(negedge clk);
        chk("R2 width", {15'd0, adc_start}, 16'd0);

        // R3 pacer period with reload 4
        wr(3'd4, 8'd4); wr(3'd5, 8'd0); wr(3'd2, 8'h01);
        begin
            int n = 0;
            int per = 0;
            while (!adc_start && n < 50) begin @(negedge clk); n++; end
            @(negedge clk);
            chk("R3 width", {15'd0, adc_start}, 16'd0);
            per = 1;
            while (!adc_start && per < 50) begin @(negedge clk); per++; end
            chk("R3 period", 16'(per), 16'd5);
        end
        wr(3'd2, 8'h00);

        // R2 trigger ignored in a paced mode
        wr(3'd4, 8'hE8); wr(3'd5, 8'h03); wr(3'd2, 8'h01);
        @(negedge clk); wr_en = 1; addr = 3'd7;
        @(negedge clk); wr_en = 0;
        chk("R2 ignored paced", {15'd0, adc_start}, 16'd0);
        wr(3'd2, 8'h00);

        // R5 overrun in holding mode
        done(12'h123);
        done(12'h456);
        rd(3'd3, rv); chk("R5 err", {8'd0, rv}, 16'h0003);
        rd(3'd0, rv); chk("R5 old kept", {8'd0, rv}, 16'h0023);

        // R6 pacer frozen while error, resumes after clear
        wr(3'd4, 8'd2); wr(3'd5, 8'd0); wr(3'd2, 8'h01);
        begin
            int seen = 0;
            for (int k = 0; k < 20; k++) begin @(negedge clk); if (adc_start) seen++; end
            chk("R6 frozen", 16'(seen), 16'd0);
            wr(3'd3, 8'h02);
            seen = 0;
            for (int k = 0; k < 10; k++) begin @(negedge clk); if (adc_start) seen++; end
            chk("R6 resumed", {15'd0, seen != 0}, 16'd1);
        end
        wr(3'd2, 8'h00);
        rd(3'd3, rv); chk("R6 cleared", {8'd0, rv}, 16'h0001);

        // R7 overrun and clear in the same cycle
        done(12'h777);                       // second unread result: err set
        cyc(1, 0, 3'd3, 8'h02, 1, 12'h555, rv);
        rd(3'd3, rv); chk("R7 err kept", {8'd0, rv[1]}, 16'd1);
        wr(3'd3, 8'h02);
        rd(3'd3, rv); chk("R7 clear alone", {8'd0, rv}, 16'h0001);

        // R8 high-byte read and result in the same cycle
        cyc(0, 1, 3'd1, 8'h00, 1, 12'h9AB, rv);
        chk("R8 popped old", {8'd0, rv}, 16'h0001);
        rd(3'd3, rv); chk("R8 no err", {8'd0, rv}, 16'h0001);
        rd(3'd0, rv); chk("R8 new low", {8'd0, rv}, 16'h00AB);
        rd(3'd1, rv); chk("R8 new high", {8'd0, rv}, 16'h0009);

        // R12 empty high read has no effect
        rd(3'd1, rv);
        rd(3'd3, rv); chk("R12 status", {8'd0, rv}, 16'h0000);
        done(12'h2C7);
        rd(3'd0, rv); chk("R12 low", {8'd0, rv}, 16'h00C7);
        rd(3'd1, rv); chk("R12 high", {8'd0, rv}, 16'h0002);
        rd(3'd3, rv); chk("R12 drained", {8'd0, rv}, 16'h0000);

        // R10 irq in holding mode
        wr(3'd2, 8'h08);
        chk("R10 idle irq", {15'd0, irq}, 16'd0);
        done(12'h011);
        chk("R10 avail irq", {15'd0, irq}, 16'd1);
        rd(3'd1, rv);
        chk("R10 irq drop", {15'd0, irq}, 16'd0);

        // R9 / R10 buffered mode
        wr(3'd2, 8'h0C);
        for (int i = 0; i < DEPTH; i++) begin
            done(SW'(i * 12'h111 + 12'h005));
            if (i == DEPTH/2 - 2) chk("R10 below half", {15'd0, irq}, 16'd0);
            if (i == DEPTH/2 - 1) chk("R10 at half", {15'd0, irq}, 16'd1);
        end
        rd(3'd3, rv); chk("R9 full no err", {8'd0, rv}, 16'h0005);
        done(12'hEEE);
        rd(3'd3, rv); chk("R9 overflow err", {8'd0, rv}, 16'h0007);
        for (int i = 0; i < DEPTH; i++) begin
            logic [SW-1:0] e;
            logic [7:0] lo, hi;
            e = SW'(i * 12'h111 + 12'h005);
            rd(3'd0, lo);
            rd(3'd1, hi);
            chk("R9 order", {4'd0, hi[3:0], lo}, {4'd0, e});
        end
        rd(3'd3, rv); chk("R9 drained", {8'd0, rv}, 16'h0002);
        wr(3'd3, 8'h02);
        rd(3'd3, rv); chk("R6 final clear", {8'd0, rv}, 16'h0000);

        finish_run();
    end
endmodule